// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the architectural bookkeeping a 32-bit embedded core performs when it takes an exception or an interrupt. Four request sources feed it: a software break, a bus fault, a non-maskable interrupt and an external interrupt. Each source has its own handler vector, except the non-maskable interrupt, which always uses vector zero. The block chooses one eligible request. It captures the core context (program counter, delay-slot offset, status word, stack pointer, kernel stack pointer and vector table base) and computes the values the core commits.

Those values are:
- the return address to save, rewound when the exception lands in a branch delay slot;
- the transformed status word, with the mode flags moved up one level;
- the exception status word, which records the vector index;
- the stack-pointer swap when the core was in user mode.

The block then reads the handler address from memory through a one-word read port. It hands that address back as the new program counter.

The core writes the special registers on a single cycle of write strobes. It sees `busy` from acceptance until the handler address is delivered, and `done` marks the one cycle in which the new program counter is valid.

Top module: `exc_entry_seq`

## Requirements
- R1: Bus fault has the highest priority, then break, then non-maskable interrupt, then external interrupt. Exactly one entry starts per acceptance. Requests are only accepted while `busy` is low, so requests held during a sequence start no second entry in that sequence.
- R2: An external interrupt is accepted only when `irq_req` is high, status bit 5 (interrupt enable) is set and `irq_lock` is low.
- R3: A non-maskable interrupt is accepted only when status bit 30 (NMI enable) is set. It uses vector 0. It writes the return address to the NMI return output with `nrp_we`, does not raise `erp_we`, and leaves bit 30 clear in the new status.
- R4: Break, bus fault and external interrupt write the return address through `erp_we` and `erp_new`. They use `trap_vec`, `fault_vec` and `irq_vec` respectively.
- R5: `xstat_new` holds the 8-bit vector in bits 15:8 and zeros in every other bit.
- R6: When `dslot_off` is nonzero at acceptance, the saved return address is `pc_cur - dslot_off` and `dslot_clr` pulses with the write strobes. Otherwise the saved return address is `pc_cur` and `dslot_clr` stays low.
- R7: When status bit 8 (user mode) is set at acceptance, `usp_we` and `sp_we` pulse with `usp_new = sp_cur` and `sp_new = ksp_cur`. Otherwise both stay low.
- R8: `status_new` equals {S[31:30], S[19:0], 10'b0}, where S is the captured status with bit 30 cleared for a non-maskable interrupt. This clears user mode.
- R9: One cycle after the write strobes, `mem_req` pulses for one cycle. It carries `mem_addr = (ebase_cur + 4*vector)` with bit 31 forced to zero.
- R10: The word returned with `mem_rvalid` appears on `pc_new` during a one-cycle `done` pulse in the cycle after `mem_rvalid`. `busy` is high from the cycle after acceptance through the `done` cycle.
- R11: After reset, `busy`, `done`, `mem_req` and all write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_req | input | 1 | Software break request |
| bflt_req | input | 1 | Bus fault request |
| irq_req | input | 1 | External interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_lock | input | 1 | Blocks external interrupt acceptance |
| trap_vec | input | 8 | Break vector |
| fault_vec | input | 8 | Bus fault vector |
| irq_vec | input | 8 | External interrupt vector |
| pc_cur | input | 32 | Current program counter |
| dslot_off | input | 2 | Delay-slot offset, nonzero when in a slot |
| status_cur | input | 32 | Current status word |
| sp_cur | input | 32 | Current stack pointer |
| ksp_cur | input | 32 | Kernel stack pointer |
| ebase_cur | input | 32 | Vector table base |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Entry in progress |
| done | output | 1 | New program counter valid |
| save_we | output | 1 | Strobe for status and exception status |
| erp_we | output | 1 | Exception return write |
| erp_new | output | 32 | Exception return value |
| nrp_we | output | 1 | NMI return write |
| nrp_new | output | 32 | NMI return value |
| usp_we | output | 1 | User stack pointer write |
| usp_new | output | 32 | User stack pointer value |
| sp_we | output | 1 | Stack pointer write |
| sp_new | output | 32 | Stack pointer value |
| dslot_clr | output | 1 | Clear delay-slot state |
| status_new | output | 32 | Transformed status word |
| xstat_new | output | 32 | Exception status word |
| mem_req | output | 1 | Handler read request |
| mem_addr | output | 32 | Handler read address |
| pc_new | output | 32 | Handler address |

## Verification
A wrongly captured cause or context shows up in the first cycle after acceptance, on the write strobes and saved values. A wrong vector shows up one cycle later as a wrong `mem_addr`. A sequencing fault shows up at the ports within four cycles of acceptance: a missing or doubled `mem_req`, a `done` that does not follow `mem_rvalid`, or a second `save_we` while requests are held. Eligibility faults appear at once as `busy` rising when it should not, or not rising when it should.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    typedef enum logic [1:0] {
        CAUSE_IRQ  = 2'd0,
        CAUSE_NMI  = 2'd1,
        CAUSE_BRK  = 2'd2,
        CAUSE_BFLT = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SAVE       = 3'd1,
        ST_FETCH_REQ  = 3'd2,
        ST_FETCH_WAIT = 3'd3,
        ST_DONE       = 3'd4
    } state_e;

    // status word layout
    localparam int unsigned IEN_BIT   = 5;
    localparam int unsigned USER_BIT  = 8;
    localparam int unsigned KEEP_HI   = 2;   // top bits preserved
    localparam int unsigned MODE_LSH  = 12;
    localparam int unsigned MODE_RSH  = 2;
    localparam int unsigned CLR_LO    = 10;  // low bits forced to zero
    localparam int unsigned XSTAT_POS = 8;   // vector field position
endpackage

// File: rtl/exc_seq_arb.sv
module exc_seq_arb
    import exc_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NMI_BIT = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              brk_req,
    input  logic              bflt_req,
    input  logic              irq_req,
    input  logic              nmi_req,
    input  logic              irq_lock,
    input  logic [DATA_W-1:0] status,
    output logic              take,
    output cause_e            cause
);
    logic irq_ok, nmi_ok;

    always_comb begin
        irq_ok = irq_req && status[IEN_BIT] && !irq_lock;
        nmi_ok = nmi_req && status[NMI_BIT];
        take   = 1'b0;
        cause  = CAUSE_IRQ;
        if (enable) begin
            if (bflt_req) begin
                take = 1'b1; cause = CAUSE_BFLT;
            end else if (brk_req) begin
                take = 1'b1; cause = CAUSE_BRK;
            end else if (nmi_ok) begin
                take = 1'b1; cause = CAUSE_NMI;
            end else if (irq_ok) begin
                take = 1'b1; cause = CAUSE_IRQ;
            end
        end
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cause == CAUSE_IRQ) |-> (irq_req && status[IEN_BIT] && !irq_lock)) // R2
        else $error("irq taken while not eligible");

    AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cause == CAUSE_NMI) |-> (nmi_req && status[NMI_BIT] && !bflt_req && !brk_req)) // R3
        else $error("nmi taken while not eligible");
endmodule

// File: rtl/exc_seq_calc.sv
module exc_seq_calc
    import exc_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned DS_W   = 2,
    parameter int unsigned NMI_BIT = DATA_W - 2
) (
    input  cause_e            cause,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [VEC_W-1:0]  fault_vec,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [DATA_W-1:0] pc,
    input  logic [DS_W-1:0]   dslot,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] ebase,
    output logic [DATA_W-1:0] ret_addr,
    output logic [DATA_W-1:0] status_nx,
    output logic [DATA_W-1:0] xstat,
    output logic [DATA_W-1:0] fetch_addr,
    output logic              user_mode,
    output logic              in_slot
);
    localparam logic [DATA_W-1:0] HI_MASK = {{KEEP_HI{1'b1}}, {(DATA_W-KEEP_HI){1'b0}}};
    localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-CLR_LO){1'b0}}, {CLR_LO{1'b1}}};

    logic [VEC_W-1:0]  vec;
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] raw_addr;

    always_comb begin
        unique case (cause)
            CAUSE_NMI:  vec = '0;
            CAUSE_BRK:  vec = trap_vec;
            CAUSE_BFLT: vec = fault_vec;
            default:    vec = irq_vec;
        endcase
        in_slot   = (dslot != '0);
        ret_addr  = pc - DATA_W'(dslot);
        user_mode = status[USER_BIT];
        pre       = status;
        if (cause == CAUSE_NMI) pre[NMI_BIT] = 1'b0;
        status_nx = ((pre & HI_MASK) | ((pre << MODE_LSH) >> MODE_RSH)) & ~LO_MASK;
        xstat     = DATA_W'(vec) << XSTAT_POS;
        raw_addr  = ebase + (DATA_W'(vec) << 2);
        fetch_addr = {1'b0, raw_addr[DATA_W-2:0]};
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned DS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_req,
    input  logic              bflt_req,
    input  logic              irq_req,
    input  logic              nmi_req,
    input  logic              irq_lock,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [VEC_W-1:0]  fault_vec,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [DATA_W-1:0] pc_cur,
    input  logic [DS_W-1:0]   dslot_off,
    input  logic [DATA_W-1:0] status_cur,
    input  logic [DATA_W-1:0] sp_cur,
    input  logic [DATA_W-1:0] ksp_cur,
    input  logic [DATA_W-1:0] ebase_cur,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              save_we,
    output logic              erp_we,
    output logic [DATA_W-1:0] erp_new,
    output logic              nrp_we,
    output logic [DATA_W-1:0] nrp_new,
    output logic              usp_we,
    output logic [DATA_W-1:0] usp_new,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_new,
    output logic              dslot_clr,
    output logic [DATA_W-1:0] status_new,
    output logic [DATA_W-1:0] xstat_new,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] pc_new
);
    localparam int unsigned NMI_BIT = DATA_W - 2;

    typedef struct packed {
        state_e            st;
        cause_e            cause;
        logic              user;
        logic              slot;
        logic [DATA_W-1:0] ret;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] xst;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] usp;
        logic [DATA_W-1:0] ksp;
        logic [DATA_W-1:0] pc;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              take;
    cause_e            cause_sel;
    logic [DATA_W-1:0] c_ret, c_stat, c_xst, c_addr;
    logic              c_user, c_slot;

    exc_seq_arb #(.DATA_W(DATA_W), .NMI_BIT(NMI_BIT)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctx_q.st == ST_IDLE),
        .brk_req  (brk_req),
        .bflt_req (bflt_req),
        .irq_req  (irq_req),
        .nmi_req  (nmi_req),
        .irq_lock (irq_lock),
        .status   (status_cur),
        .take     (take),
        .cause    (cause_sel)
    );

    exc_seq_calc #(.DATA_W(DATA_W), .VEC_W(VEC_W), .DS_W(DS_W), .NMI_BIT(NMI_BIT)) u_calc (
        .cause      (cause_sel),
        .trap_vec   (trap_vec),
        .fault_vec  (fault_vec),
        .irq_vec    (irq_vec),
        .pc         (pc_cur),
        .dslot      (dslot_off),
        .status     (status_cur),
        .ebase      (ebase_cur),
        .ret_addr   (c_ret),
        .status_nx  (c_stat),
        .xstat      (c_xst),
        .fetch_addr (c_addr),
        .user_mode  (c_user),
        .in_slot    (c_slot)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (take) begin
                    ctx_d.st    = ST_SAVE;
                    ctx_d.cause = cause_sel;
                    ctx_d.user  = c_user;
                    ctx_d.slot  = c_slot;
                    ctx_d.ret   = c_ret;
                    ctx_d.stat  = c_stat;
                    ctx_d.xst   = c_xst;
                    ctx_d.addr  = c_addr;
                    ctx_d.usp   = sp_cur;
                    ctx_d.ksp   = ksp_cur;
                end
            end
            ST_SAVE:      ctx_d.st = ST_FETCH_REQ;
            ST_FETCH_REQ: ctx_d.st = ST_FETCH_WAIT;
            ST_FETCH_WAIT: begin
                if (mem_rvalid) begin
                    ctx_d.st = ST_DONE;
                    ctx_d.pc = mem_rdata;
                end
            end
            default:      ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, cause: CAUSE_IRQ, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy       = (ctx_q.st != ST_IDLE);
    assign save_we    = (ctx_q.st == ST_SAVE);
    assign erp_we     = save_we && (ctx_q.cause != CAUSE_NMI);
    assign nrp_we     = save_we && (ctx_q.cause == CAUSE_NMI);
    assign erp_new    = ctx_q.ret;
    assign nrp_new    = ctx_q.ret;
    assign usp_we     = save_we && ctx_q.user;
    assign sp_we      = save_we && ctx_q.user;
    assign usp_new    = ctx_q.usp;
    assign sp_new     = ctx_q.ksp;
    assign dslot_clr  = save_we && ctx_q.slot;
    assign status_new = ctx_q.stat;
    assign xstat_new  = ctx_q.xst;
    assign mem_req    = (ctx_q.st == ST_FETCH_REQ);
    assign mem_addr   = ctx_q.addr;
    assign done       = (ctx_q.st == ST_DONE);
    assign pc_new     = ctx_q.pc;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R10
        else $error("done longer than one cycle");

    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_rvalid)) // R10
        else $error("done without read data");

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req) // R9
        else $error("fetch request longer than one cycle");

    AST_FETCH_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(save_we)) // R9
        else $error("fetch not preceded by save");

    AST_RETURN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        nrp_we |-> !erp_we) // R3
        else $error("both return registers written");

    AST_SAVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        save_we |=> (busy && !save_we)) // R1
        else $error("second save in one sequence");
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic brk_req = 0, bflt_req = 0, irq_req = 0, nmi_req = 0, irq_lock = 0;
    logic [7:0]  trap_vec = 0, fault_vec = 0, irq_vec = 0;
    logic [31:0] pc_cur = 0, status_cur = 0, sp_cur = 0, ksp_cur = 0, ebase_cur = 0;
    logic [1:0]  dslot_off = 0;
    logic        mem_rvalid = 0;
    logic [31:0] mem_rdata = 0;
    logic busy, done, save_we, erp_we, nrp_we, usp_we, sp_we, dslot_clr, mem_req;
    logic [31:0] erp_new, nrp_new, usp_new, sp_new, status_new, xstat_new, mem_addr, pc_new;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .bflt_req(bflt_req),
        .irq_req(irq_req), .nmi_req(nmi_req), .irq_lock(irq_lock),
        .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
        .pc_cur(pc_cur), .dslot_off(dslot_off), .status_cur(status_cur),
        .sp_cur(sp_cur), .ksp_cur(ksp_cur), .ebase_cur(ebase_cur),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .save_we(save_we),
        .erp_we(erp_we), .erp_new(erp_new), .nrp_we(nrp_we), .nrp_new(nrp_new),
        .usp_we(usp_we), .usp_new(usp_new), .sp_we(sp_we), .sp_new(sp_new),
        .dslot_clr(dslot_clr), .status_new(status_new), .xstat_new(xstat_new),
        .mem_req(mem_req), .mem_addr(mem_addr), .pc_new(pc_new)
    );

    // memory model: data two half-cycles after the request is seen
    logic        pend = 0;
    logic [31:0] pend_addr = 0;
    always @(negedge clk) begin
        mem_rvalid <= pend;
        mem_rdata  <= pend_addr ^ 32'hC3C3_0000;
        pend       <= mem_req;
        pend_addr  <= mem_addr;
    end

    // observations of one sequence
    int          n_save, n_req, n_done;
    logic        seen_busy, o_erp_we, o_nrp_we, o_usp_we, o_sp_we, o_dclr;
    logic [31:0] o_erp, o_nrp, o_usp, o_sp, o_stat, o_xst, o_addr, o_pc;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input logic [31:0] s, input logic nmi);
        logic [31:0] t;
        t = s;
        if (nmi) t[30] = 1'b0;
        return {t[31:30], t[19:0], 10'b0};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] eb, input logic [7:0] v);
        return (eb + {22'b0, v, 2'b00}) & 32'h7FFF_FFFF;
    endfunction

    // hold=1 keeps requests asserted until done
    task automatic fire(input logic b, input logic f, input logic i, input logic n, input logic hold);
        n_save = 0; n_req = 0; n_done = 0; seen_busy = 0;
        o_erp_we = 0; o_nrp_we = 0; o_usp_we = 0; o_sp_we = 0; o_dclr = 0;
        @(negedge clk);
        brk_req = b; bflt_req = f; irq_req = i; nmi_req = n;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (busy) seen_busy = 1;
            if (save_we) begin
                n_save++;
                o_erp_we = erp_we; o_erp = erp_new; o_nrp_we = nrp_we; o_nrp = nrp_new;
                o_usp_we = usp_we; o_usp = usp_new; o_sp_we = sp_we; o_sp = sp_new;
                o_dclr = dslot_clr; o_stat = status_new; o_xst = xstat_new;
            end
            if (mem_req) begin n_req++; o_addr = mem_addr; end
            if (done) begin n_done++; o_pc = pc_new; end
            if ((!hold && k == 0) || (hold && done)) begin
                brk_req = 0; bflt_req = 0; irq_req = 0; nmi_req = 0;
            end
        end
    endtask

    task automatic t_reset;
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 mem_req", mem_req, 0);
        chk("R11 save_we", {save_we, erp_we, nrp_we, usp_we, sp_we, dslot_clr}, 0);
    endtask

    task automatic t_irq_basic;
        pc_cur = 32'h0000_1000; status_cur = 32'h0000_0020; irq_vec = 8'h21;
        ebase_cur = 32'h8000_0100; dslot_off = 0; irq_lock = 0;
        fire(0, 0, 1, 0, 0);
        chk("R2 irq accepted", n_save, 1);
        chk("R4 erp_we", o_erp_we, 1);
        chk("R4 erp value", o_erp, 32'h0000_1000);
        chk("R3 nrp_we low for irq", o_nrp_we, 0);
        chk("R5 xstat", o_xst, 32'h0000_2100);
        chk("R8 status", o_stat, exp_status(32'h0000_0020, 0));
        chk("R7 no swap in kernel", {o_usp_we, o_sp_we}, 0);
        chk("R6 no slot clear", o_dclr, 0);
        chk("R9 one fetch", n_req, 1);
        chk("R9 fetch addr", o_addr, 32'h0000_0184);
        chk("R10 one done", n_done, 1);
        chk("R10 new pc", o_pc, 32'h0000_0184 ^ 32'hC3C3_0000);
        chk("R10 busy seen", seen_busy, 1);
    endtask

    task automatic t_irq_blocked;
        status_cur = 32'h0000_0000; irq_lock = 0;
        fire(0, 0, 1, 0, 0);
        chk("R2 masked irq ignored", {n_save[0], seen_busy}, 0);
        status_cur = 32'h0000_0020; irq_lock = 1;
        fire(0, 0, 1, 0, 0);
        chk("R2 locked irq ignored", {n_save[0], seen_busy}, 0);
        irq_lock = 0;
    endtask

    task automatic t_nmi;
        pc_cur = 32'h0000_2468; status_cur = 32'h4000_0020; ebase_cur = 32'h0001_0000;
        fire(0, 0, 0, 1, 0);
        chk("R3 nmi accepted", n_save, 1);
        chk("R3 nrp_we", o_nrp_we, 1);
        chk("R3 nrp value", o_nrp, 32'h0000_2468);
        chk("R3 erp_we low", o_erp_we, 0);
        chk("R3 M cleared", o_stat[30], 0);
        chk("R8 nmi status", o_stat, exp_status(32'h4000_0020, 1));
        chk("R5 xstat vec0", o_xst, 0);
        chk("R9 nmi addr", o_addr, 32'h0001_0000);
        status_cur = 32'h0000_0020;
        fire(0, 0, 0, 1, 0);
        chk("R3 nmi masked ignored", {n_save[0], seen_busy}, 0);
    endtask

    task automatic t_nmi_over_irq;
        status_cur = 32'h4000_0020; irq_vec = 8'h33; ebase_cur = 32'h0000_0400;
        fire(0, 0, 1, 1, 0);
        chk("R1 nmi wins over irq", o_nrp_we, 1);
        chk("R1 nmi vector used", o_addr, 32'h0000_0400);
        chk("R1 single entry", n_save, 1);
    endtask

    task automatic t_break_slot_user;
        pc_cur = 32'h0000_5006; dslot_off = 2'd2; status_cur = 32'hC008_0120;
        sp_cur = 32'h1234_5678; ksp_cur = 32'h9ABC_DEF0; trap_vec = 8'h07;
        ebase_cur = 32'hFFFF_FF00;
        fire(1, 0, 0, 0, 0);
        chk("R4 break erp_we", o_erp_we, 1);
        chk("R6 rewound return", o_erp, 32'h0000_5004);
        chk("R6 slot clear", o_dclr, 1);
        chk("R7 usp_we", o_usp_we, 1);
        chk("R7 usp value", o_usp, 32'h1234_5678);
        chk("R7 sp_we", o_sp_we, 1);
        chk("R7 sp value", o_sp, 32'h9ABC_DEF0);
        chk("R8 status user", o_stat, exp_status(32'hC008_0120, 0));
        chk("R8 user cleared", o_stat[8], 0);
        chk("R5 trap xstat", o_xst, 32'h0000_0700);
        chk("R9 wrapped addr bit31", o_addr, exp_addr(32'hFFFF_FF00, 8'h07));
        dslot_off = 0;
    endtask

    task automatic t_fault_priority;
        pc_cur = 32'h0000_0800; status_cur = 32'h4000_0020; trap_vec = 8'h05;
        fault_vec = 8'h0B; ebase_cur = 32'h0000_2000;
        fire(1, 1, 1, 1, 0);
        chk("R1 fault wins", o_xst, 32'h0000_0B00);
        chk("R4 fault erp", o_erp, 32'h0000_0800);
        chk("R9 fault addr", o_addr, 32'h0000_202C);
        fire(1, 0, 1, 1, 0);
        chk("R1 break over nmi", o_xst, 32'h0000_0500);
        chk("R1 break uses erp", {o_erp_we, o_nrp_we}, 2'b10);
    endtask

    task automatic t_held_request;
        status_cur = 32'h0000_0020; irq_vec = 8'h12; ebase_cur = 0;
        fire(0, 0, 1, 0, 1);
        chk("R1 held irq one entry", n_save, 1);
        chk("R1 held irq one done", n_done, 1);
        chk("R10 pc held case", o_pc, 32'h0000_0048 ^ 32'hC3C3_0000);
    endtask

    logic finished = 0;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_irq_basic();
        t_irq_blocked();
        t_nmi();
        t_nmi_over_irq();
        t_break_slot_user();
        t_fault_priority();
        t_held_request();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule